// File: doc/BRIEF.md
# Programmable Burst Read Latency Controller

This block sits on the device side of a synchronous burst read interface. When the host samples its active-low address strobe low, the block captures the start address and the current configuration. It counts off a programmable initial access latency and then streams word addresses to an external array model, one word per data beat. The host sees a `ready` indication and a `data_valid` strobe. Both drop low during the initial latency, during any wait state inserted at an address boundary, and during the idle gap of the half-rate mode.

A small configuration write port sets three things. The first is a 3-bit latency code that selects the total initial access cycle count, where two codes are reserved. The second is a boundary-crossing wait enable. The third is a clock-rate bit that selects one beat per cycle or one beat every two cycles. Each burst runs under a snapshot of the configuration taken when the burst starts. A new strobe sample at any time aborts the current burst and starts a fresh one.

Top module: `burst_latency_ctrl`

## Requirements
- R1: With latency code c in {0..5}, the total initial access count is N = c + 2. Cycle 0 is the cycle after the clock edge that samples `addr_strobe_n` low, and the first word appears with `data_valid` high in cycle N-1.
- R2: A configuration write carrying latency code 6 or 7 leaves the stored latency code unchanged. The other two configuration bits are still written.
- R3: Synchronous reset sets the latency code to 5 (N = 7), the boundary wait enable to 1 and the clock-rate bit to 1. While reset is applied and in the cycle after, `ready` and `data_valid` are low.
- R4: For N >= 3, `ready` rises in cycle N-2, one cycle ahead of the first word, while `data_valid` is still low. For N = 2, `ready` stays low in cycle 0 and rises together with the first word in cycle 1.
- R5: `data_valid` never goes high without `ready`. Apart from the early cycle of R4, `ready` is low in every cycle without a delivered word.
- R6: The first word address equals the captured start address, and each later word address is one more than the previous one. Exactly BURST_LEN words are delivered, each with a single-cycle `data_valid`, and after that both outputs return low.
- R7: When the captured boundary enable is 1, one cycle with `ready` and `data_valid` low is inserted before any word whose address has its low 4 bits equal to zero, unless it is the first word. With the enable at 0, no such cycle is inserted.
- R8: With the captured clock-rate bit at 1, words arrive on consecutive cycles. At 0, one idle cycle is placed between consecutive words, in addition to any boundary wait.
- R9: A low sample of `addr_strobe_n` during latency or transfer abandons the current burst. Timing restarts from that edge with the newly presented start address.
- R10: A burst uses the configuration stored before its starting edge. A write in the same cycle as the strobe, or during the burst, only affects later bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe_n | input | 1 | Active-low address-valid strobe, sampled each rising edge |
| start_addr | input | AW | Start word address, captured with the strobe |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_wait | input | 3 | Latency code, N = code + 2, codes 6 and 7 reserved |
| cfg_cross_wait | input | 1 | Boundary-crossing wait enable |
| cfg_full_rate | input | 1 | 1: a beat every cycle; 0: a beat every second cycle |
| ready | output | 1 | Ready indication to the host |
| data_valid | output | 1 | One pulse per delivered word |
| word_addr | output | AW | Address of the word being delivered |

## Verification
A corrupted latency counter or a wrongly decoded code moves the first `data_valid` pulse and the early `ready` away from cycles N-1 and N-2. This shows within at most seven cycles of the strobe. A wrong address register or beat counter shows at the first skipped or repeated `word_addr` value, or as a burst ending too early or too late. Missing boundary or gap handling shows one cycle after the crossing word, because a word appears where the host expects an idle cycle. A configuration snapshot taken at the wrong edge shows as the old or new latency applied to the wrong burst.

// File: rtl/blc_pkg.sv
package blc_pkg;

    localparam int CODE_W = 3;

    typedef logic [CODE_W-1:0] wcode_t;

    typedef struct packed {
        wcode_t wait_code;
        logic   cross_wait;
        logic   full_rate;
    } blc_cfg_t;

    localparam wcode_t   RESET_CODE = 3'd5;
    localparam blc_cfg_t RESET_CFG  = '{wait_code: RESET_CODE, cross_wait: 1'b1, full_rate: 1'b1};

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_XFER = 1'b1
    } seq_state_e;

    function automatic logic code_reserved(wcode_t c);
        return c > 3'd5;
    endfunction

    function automatic logic [2:0] code_cycles(wcode_t c);
        return c + 3'd2;
    endfunction

endpackage

// File: rtl/blc_cfg_reg.sv
module blc_cfg_reg
    import blc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  blc_cfg_t wdata,
    output blc_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= RESET_CFG;
        end else if (wr) begin
            if (!code_reserved(wdata.wait_code)) begin
                cfg_q.wait_code <= wdata.wait_code;
            end
            cfg_q.cross_wait <= wdata.cross_wait;
            cfg_q.full_rate  <= wdata.full_rate;
        end
    end

    // R2
    reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && code_reserved(wdata.wait_code)) |=> (cfg_q.wait_code == $past(cfg_q.wait_code)));

endmodule

// File: rtl/blc_lat_timer.sv
module blc_lat_timer
    import blc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  wcode_t   code,
    output logic     lat_done,
    output logic     early_rdy
);

    logic [2:0] cnt_q;
    logic       active_q;
    logic       min_lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            active_q  <= 1'b0;
            min_lat_q <= 1'b0;
        end else if (start) begin
            cnt_q     <= code_cycles(code) - 3'd1;
            active_q  <= 1'b1;
            min_lat_q <= (code == 3'd0);
        end else if (active_q) begin
            if (cnt_q == 3'd1) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 3'd1;
            end
        end
    end

    assign lat_done  = active_q && (cnt_q == 3'd1);
    assign early_rdy = lat_done && !min_lat_q;

    // R1
    start_arms_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> active_q);

    // R4
    min_lat_no_early_chk: assert property (@(posedge clk) disable iff (rst)
        (start && code == 3'd0) |=> !early_rdy);

endmodule

// File: rtl/blc_beat_seq.sv
module blc_beat_seq
    import blc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BURST_LEN = 20,
    parameter int BND_BITS  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          load,
    input  logic [AW-1:0] base_addr,
    input  logic          cross_wait,
    input  logic          full_rate,
    output logic          beat,
    output logic [AW-1:0] addr_o
);

    localparam int LW = $clog2(BURST_LEN + 1);

    seq_state_e    st_q;
    logic [LW-1:0] left_q;
    logic          gap_q;
    logic          bwait_q;
    logic [AW-1:0] nxt;
    logic          nxt_on_bnd;

    assign nxt        = addr_o + AW'(1);
    assign nxt_on_bnd = (nxt[BND_BITS-1:0] == '0);
    assign beat       = (st_q == SEQ_XFER) && !gap_q && !bwait_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st_q    <= SEQ_IDLE;
            left_q  <= '0;
            gap_q   <= 1'b0;
            bwait_q <= 1'b0;
            addr_o  <= '0;
        end else if (load) begin
            st_q    <= SEQ_XFER;
            left_q  <= LW'(BURST_LEN);
            gap_q   <= 1'b0;
            bwait_q <= 1'b0;
            addr_o  <= base_addr;
        end else if (st_q == SEQ_XFER) begin
            if (bwait_q) begin
                bwait_q <= 1'b0;
            end else if (gap_q) begin
                gap_q <= 1'b0;
            end else if (left_q == LW'(1)) begin
                st_q <= SEQ_IDLE;
            end else begin
                addr_o  <= nxt;
                left_q  <= left_q - LW'(1);
                gap_q   <= !full_rate;
                bwait_q <= cross_wait && nxt_on_bnd;
            end
        end
    end

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (beat && !abort) |=> (!beat || addr_o == $past(addr_o) + AW'(1)));

    // R8
    half_rate_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (beat && !full_rate && !abort) |=> !beat);

endmodule

// File: rtl/burst_latency_ctrl.sv
module burst_latency_ctrl
    import blc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BURST_LEN = 20,
    parameter int BND_BITS  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_strobe_n,
    input  logic [AW-1:0] start_addr,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_wait,
    input  logic          cfg_cross_wait,
    input  logic          cfg_full_rate,
    output logic          ready,
    output logic          data_valid,
    output logic [AW-1:0] word_addr
);

    blc_cfg_t      cfg_q;
    blc_cfg_t      cfg_wdata;
    blc_cfg_t      snap_q;
    logic [AW-1:0] snap_addr_q;
    logic          start;
    logic          lat_done;
    logic          early_rdy;
    logic          beat;

    assign start     = !addr_strobe_n;
    assign cfg_wdata = '{wait_code: cfg_wait, cross_wait: cfg_cross_wait, full_rate: cfg_full_rate};

    blc_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q      <= RESET_CFG;
            snap_addr_q <= '0;
        end else if (start) begin
            snap_q      <= cfg_q;
            snap_addr_q <= start_addr;
        end
    end

    blc_lat_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .code      (cfg_q.wait_code),
        .lat_done  (lat_done),
        .early_rdy (early_rdy)
    );

    blc_beat_seq #(
        .AW        (AW),
        .BURST_LEN (BURST_LEN),
        .BND_BITS  (BND_BITS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .abort      (start),
        .load       (lat_done),
        .base_addr  (snap_addr_q),
        .cross_wait (snap_q.cross_wait),
        .full_rate  (snap_q.full_rate),
        .beat       (beat),
        .addr_o     (word_addr)
    );

    assign data_valid = beat;
    assign ready      = beat || early_rdy;

    // R5
    valid_has_ready_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> ready);

    // R4
    early_ready_then_data_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !data_valid && !start) |=> data_valid);

    // R7
    boundary_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (data_valid && snap_q.cross_wait && word_addr[BND_BITS-1:0] == '1 && !start)
            |=> (!data_valid && !ready));

endmodule

// File: tb/burst_latency_ctrl_tb.sv
module burst_latency_ctrl_tb;

    localparam int AW  = 16;
    localparam int LEN = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          addr_strobe_n = 1'b1;
    logic [AW-1:0] start_addr = '0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_wait = 3'd0;
    logic          cfg_cross_wait = 1'b0;
    logic          cfg_full_rate = 1'b1;
    logic          ready;
    logic          data_valid;
    logic [AW-1:0] word_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    burst_latency_ctrl #(.AW(AW), .BURST_LEN(LEN), .BND_BITS(4)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .addr_strobe_n  (addr_strobe_n),
        .start_addr     (start_addr),
        .cfg_wr         (cfg_wr),
        .cfg_wait       (cfg_wait),
        .cfg_cross_wait (cfg_cross_wait),
        .cfg_full_rate  (cfg_full_rate),
        .ready          (ready),
        .data_valid     (data_valid),
        .word_addr      (word_addr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not complete (cycle %0d, expected < 60000)", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic r, input logic d, input logic [AW-1:0] a,
                         input logic er, input logic ed, input logic [AW-1:0] ea);
        n_tests = n_tests + 1;
        if (r !== er || d !== ed || (ed && a !== ea)) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: ready/valid/addr = %b/%b/%h, expected %b/%b/%h", req, r, d, a, er, ed, ea);
        end
    endtask

    task automatic write_cfg(input logic [2:0] c, input logic bw, input logic fr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wait = c; cfg_cross_wait = bw; cfg_full_rate = fr;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Sample strobe low at the next rising edge; return inside cycle 0.
    task automatic pulse_start(input logic [AW-1:0] a);
        @(negedge clk);
        addr_strobe_n = 1'b0; start_addr = a;
        @(negedge clk);
        addr_strobe_n = 1'b1; start_addr = ~a;
        #1;
    endtask

    // Compare cycles 0.. of a burst; limit 0 means whole burst plus one idle cycle.
    task automatic check_timeline(input string req, input logic [AW-1:0] a0, input int n,
                                  input logic bw, input logic fr, input int limit);
        logic          er [0:127];
        logic          ed [0:127];
        logic [AW-1:0] ea [0:127];
        int len = 0;
        for (int k = 0; k <= n - 2; k++) begin
            er[len] = (n > 2) && (k == n - 2); ed[len] = 1'b0; ea[len] = '0; len++;
        end
        for (int b = 0; b < LEN; b++) begin
            logic [AW-1:0] a;
            a = a0 + AW'(b);
            if (b > 0) begin
                if (!fr) begin er[len] = 1'b0; ed[len] = 1'b0; ea[len] = '0; len++; end
                if (bw && a[3:0] == 4'h0) begin er[len] = 1'b0; ed[len] = 1'b0; ea[len] = '0; len++; end
            end
            er[len] = 1'b1; ed[len] = 1'b1; ea[len] = a; len++;
        end
        er[len] = 1'b0; ed[len] = 1'b0; ea[len] = '0; len++;
        for (int i = 0; i < len; i++) begin
            if (limit > 0 && i >= limit) break;
            if (i > 0) begin @(negedge clk); #1; end
            check(req, ready, data_valid, word_addr, er[i], ed[i], ea[i]);
        end
    endtask

    task automatic t_reset_state;
        // R3: outputs low after reset
        check("R3", ready, data_valid, word_addr, 1'b0, 1'b0, '0);
        @(negedge clk); #1;
        check("R3", ready, data_valid, word_addr, 1'b0, 1'b0, '0);
        // R3 / R1 / R7: default 7 cycles, boundary wait on, full rate
        pulse_start(16'h010C);
        check_timeline("R3", 16'h010C, 7, 1'b1, 1'b1, 0);
    endtask

    task automatic t_codes;
        // R1 / R4 / R6: each legal code, aligned start, no boundary wait
        for (int c = 0; c < 6; c++) begin
            write_cfg(3'(c), 1'b0, 1'b1);
            pulse_start(16'h0200);
            check_timeline("R1", 16'h0200, c + 2, 1'b0, 1'b1, 0);
        end
        // R4: minimum latency, ready with the data only
        write_cfg(3'd0, 1'b0, 1'b1);
        pulse_start(16'h0040);
        check_timeline("R4", 16'h0040, 2, 1'b0, 1'b1, 0);
    endtask

    task automatic t_reserved;
        // R2: code 7 ignored, other bits taken (boundary wait turns on)
        write_cfg(3'd0, 1'b0, 1'b1);
        write_cfg(3'd7, 1'b1, 1'b1);
        pulse_start(16'h0009);
        check_timeline("R2", 16'h0009, 2, 1'b1, 1'b1, 0);
        write_cfg(3'd6, 1'b0, 1'b1);
        pulse_start(16'h0009);
        check_timeline("R2", 16'h0009, 2, 1'b0, 1'b1, 0);
    endtask

    task automatic t_boundary;
        // R7: crossing with and without the wait enabled
        write_cfg(3'd1, 1'b1, 1'b1);
        pulse_start(16'h00FA);
        check_timeline("R7", 16'h00FA, 3, 1'b1, 1'b1, 0);
        write_cfg(3'd1, 1'b0, 1'b1);
        pulse_start(16'h00FA);
        check_timeline("R7", 16'h00FA, 3, 1'b0, 1'b1, 0);
        // R7: aligned first word gets no wait, crossing at 0x30 later
        write_cfg(3'd2, 1'b1, 1'b1);
        pulse_start(16'h0020);
        check_timeline("R7", 16'h0020, 4, 1'b1, 1'b1, 0);
    endtask

    task automatic t_half_rate;
        // R8: gap between words, plus boundary wait stacking
        write_cfg(3'd3, 1'b0, 1'b0);
        pulse_start(16'h0007);
        check_timeline("R8", 16'h0007, 5, 1'b0, 1'b0, 0);
        write_cfg(3'd0, 1'b1, 1'b0);
        pulse_start(16'h000E);
        check_timeline("R8", 16'h000E, 2, 1'b1, 1'b0, 0);
    endtask

    task automatic t_abort;
        // R9: restart during latency
        write_cfg(3'd5, 1'b0, 1'b1);
        pulse_start(16'h1000);
        check_timeline("R9", 16'h1000, 7, 1'b0, 1'b1, 3);
        pulse_start(16'h2000);
        check_timeline("R9", 16'h2000, 7, 1'b0, 1'b1, 0);
        // R9: restart during transfer
        write_cfg(3'd0, 1'b0, 1'b1);
        pulse_start(16'h3000);
        check_timeline("R9", 16'h3000, 2, 1'b0, 1'b1, 5);
        pulse_start(16'h4004);
        check_timeline("R9", 16'h4004, 2, 1'b0, 1'b1, 0);
    endtask

    task automatic t_snapshot;
        // R10: write in the strobe cycle does not affect this burst
        write_cfg(3'd4, 1'b0, 1'b1);
        @(negedge clk);
        addr_strobe_n = 1'b0; start_addr = 16'h0500;
        cfg_wr = 1'b1; cfg_wait = 3'd0; cfg_cross_wait = 1'b0; cfg_full_rate = 1'b0;
        @(negedge clk);
        addr_strobe_n = 1'b1; cfg_wr = 1'b0; start_addr = '0;
        #1;
        check_timeline("R10", 16'h0500, 6, 1'b0, 1'b1, 0);
        // R10: write during a burst affects only the next one
        write_cfg(3'd5, 1'b0, 1'b1);
        pulse_start(16'h0600);
        fork
            check_timeline("R10", 16'h0600, 7, 1'b0, 1'b1, 0);
            begin
                @(negedge clk);
                cfg_wr = 1'b1; cfg_wait = 3'd1; cfg_cross_wait = 1'b1; cfg_full_rate = 1'b0;
                @(negedge clk);
                cfg_wr = 1'b0;
            end
        join
        pulse_start(16'h060C);
        check_timeline("R10", 16'h060C, 3, 1'b1, 1'b0, 0);
    endtask

    task automatic t_reset_restore;
        // R3: reset restores defaults after other writes
        write_cfg(3'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R3", ready, data_valid, word_addr, 1'b0, 1'b0, '0);
        pulse_start(16'h00F8);
        check_timeline("R3", 16'h00F8, 7, 1'b1, 1'b1, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset_state();
        t_codes();
        t_reserved();
        t_boundary();
        t_half_rate();
        t_abort();
        t_snapshot();
        t_reset_restore();
        // R5 / R6: the cycle-accurate timelines above cover ready/valid pairing and word count
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule